// File: doc/BRIEF.md
# Multi-cycle register-file microprocessor

This block is a small 16-bit processor made of a controller state machine and a datapath. The datapath holds a program counter, an instruction register, a sixteen-entry register file with two read ports and one write port, and an ALU with a zero output. Each instruction takes exactly three clock cycles: one to fetch, one to decode and one to execute. There are seven operations: direct load, direct store, register-indirect store, load-immediate, add, subtract and jump-if-zero. Every other opcode does nothing.

The processor reaches one external word-addressed memory through a single plain port. Reads are combinational: the memory answers in the same cycle as the address. A write takes effect on the rising clock edge while the write enable is high. The memory always answers at once, so the port has no valid/ready pair and cannot apply back-pressure; a request and its data are always in the same cycle.

Top module: `fsmd_cpu`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, the block fetches from address 0: `mem_addr` = 0, `mem_re` = 1, `mem_we` = 0.
- R2: A fetch reads the word at the program counter into the instruction register and adds one to the counter. Every instruction takes exactly three cycles (fetch, decode, execute), so fetches of consecutive instructions are three cycles apart.
- R3: The instruction word is split into fixed fields. The opcode is bits [15:12], the first register index rn is bits [11:8], and the second register index rm is bits [7:4]. The 8-bit field in bits [7:0] serves as the direct address, the immediate value and the jump target.
- R4: Opcode 0x0 loads rn from memory at the direct address. Opcode 0x1 writes rn to memory at the direct address.
- R5: Opcode 0x2 writes register rm to the memory address held in register rn.
- R6: Opcode 0x3 writes the 8-bit field into rn. This field, and any field used as an address or jump target, is zero-extended to 16 bits.
- R7: Opcode 0x4 sets rn = rn + rm, and opcode 0x5 sets rn = rn − rm. Both wrap modulo 2^16, so 0 − 1 gives 0xFFFF.
- R8: Opcode 0x6 loads the program counter with the 8-bit field when rn is zero. Otherwise the counter keeps the incremented value from the fetch.
- R9: Opcodes 0x7 to 0xF change no register and no memory word. The next instruction is fetched three cycles after the fetch of the no-op.
- R10: `mem_re` is high only in fetch and direct-load cycles. `mem_we` is high only in the execute cycle of a store. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 16 | Word address to memory |
| mem_wdata | output | 16 | Data to write |
| mem_rdata | input | 16 | Data read back in the same cycle |
| mem_re | output | 1 | Read enable |
| mem_we | output | 1 | Write enable, takes effect at the clock edge |

## Verification
Register contents cannot be seen at the ports, so the hard case is to prove that arithmetic, branches and no-ops left the registers right. A program held in the bench memory runs a ten-step countdown sum. The loop exits only after the zero test has failed ten times and then succeeded once. The program then stores the results, an underflowed difference and a zero-extended immediate back to memory. Each store is compared in order against a queue of expected writes. One final store, made after two no-ops, shows that the no-ops left the register file untouched.

// File: rtl/fsmd_pkg.sv
package fsmd_pkg;
  typedef enum logic [3:0] {
    S_FETCH, S_DECODE, S_LDD, S_STD, S_STI, S_LDI, S_ADD, S_SUB, S_JZ, S_NOP
  } state_t;

  typedef enum logic [1:0] {ALU_ADD = 2'd0, ALU_SUB = 2'd1, ALU_PASS = 2'd2} alu_op_t;
  typedef enum logic [1:0] {WSEL_ALU = 2'd0, WSEL_MEM = 2'd1, WSEL_IMM = 2'd2} wsel_t;
  typedef enum logic [1:0] {ASEL_PC = 2'd0, ASEL_DIR = 2'd1, ASEL_REG = 2'd2} asel_t;

  localparam logic [3:0] OPC_LDD = 4'h0;
  localparam logic [3:0] OPC_STD = 4'h1;
  localparam logic [3:0] OPC_STI = 4'h2;
  localparam logic [3:0] OPC_LDI = 4'h3;
  localparam logic [3:0] OPC_ADD = 4'h4;
  localparam logic [3:0] OPC_SUB = 4'h5;
  localparam logic [3:0] OPC_JZ  = 4'h6;

  typedef struct packed {
    logic    ir_ld;
    logic    pc_inc;
    logic    pc_jz;
    logic    rf_we;
    wsel_t   wsel;
    asel_t   asel;
    alu_op_t alu_op;
    logic    wdata_rm;
    logic    mem_re;
    logic    mem_we;
  } ctrl_t;
endpackage

// File: rtl/fsmd_regfile.sv
module fsmd_regfile #(
  parameter int W     = 16,
  parameter int NREGS = 16,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra1,
  output logic [W-1:0]  rd1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd2
);
  logic [W-1:0] regs [NREGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (we) begin
      regs[wa] <= wd;
    end
  end

  assign rd1 = regs[ra1];
  assign rd2 = regs[ra2];
endmodule

// File: rtl/fsmd_alu.sv
module fsmd_alu
  import fsmd_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_t      op,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      default: y = a;
    endcase
  end

  assign zero = (y == '0);
endmodule

// File: rtl/fsmd_ctrl.sv
module fsmd_ctrl
  import fsmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] opcode,
  output state_t     state,
  output ctrl_t      ctl
);
  state_t nxt;

  always_comb begin
    nxt = S_FETCH;
    case (state)
      S_FETCH:  nxt = S_DECODE;
      S_DECODE: begin
        case (opcode)
          OPC_LDD: nxt = S_LDD;
          OPC_STD: nxt = S_STD;
          OPC_STI: nxt = S_STI;
          OPC_LDI: nxt = S_LDI;
          OPC_ADD: nxt = S_ADD;
          OPC_SUB: nxt = S_SUB;
          OPC_JZ:  nxt = S_JZ;
          default: nxt = S_NOP;
        endcase
      end
      default:  nxt = S_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_FETCH;
    else     state <= nxt;
  end

  always_comb begin
    ctl = '0;
    case (state)
      S_FETCH: begin
        ctl.asel   = ASEL_PC;
        ctl.mem_re = 1'b1;
        ctl.ir_ld  = 1'b1;
        ctl.pc_inc = 1'b1;
      end
      S_LDD: begin
        ctl.asel   = ASEL_DIR;
        ctl.mem_re = 1'b1;
        ctl.rf_we  = 1'b1;
        ctl.wsel   = WSEL_MEM;
      end
      S_STD: begin
        ctl.asel   = ASEL_DIR;
        ctl.mem_we = 1'b1;
      end
      S_STI: begin
        ctl.asel     = ASEL_REG;
        ctl.wdata_rm = 1'b1;
        ctl.mem_we   = 1'b1;
      end
      S_LDI: begin
        ctl.rf_we = 1'b1;
        ctl.wsel  = WSEL_IMM;
      end
      S_ADD: begin
        ctl.rf_we  = 1'b1;
        ctl.wsel   = WSEL_ALU;
        ctl.alu_op = ALU_ADD;
      end
      S_SUB: begin
        ctl.rf_we  = 1'b1;
        ctl.wsel   = WSEL_ALU;
        ctl.alu_op = ALU_SUB;
      end
      S_JZ: begin
        ctl.alu_op = ALU_PASS;
        ctl.pc_jz  = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/fsmd_cpu.sv
module fsmd_cpu
  import fsmd_pkg::*;
#(
  parameter int W     = 16,
  parameter int NREGS = 16
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  input  logic [W-1:0] mem_rdata,
  output logic         mem_re,
  output logic         mem_we
);
  localparam int RSEL_W = $clog2(NREGS);
  localparam int FLD_W  = 8;
  localparam int OPC_LO = 12;
  localparam int RN_LO  = 8;
  localparam int RM_LO  = 4;

  logic [W-1:0]      pc_q, ir_q;
  logic [W-1:0]      rf_rd1, rf_rd2, rf_wd, alu_y, fld_ext;
  logic              alu_z;
  logic [3:0]        opc;
  logic [RSEL_W-1:0] rn, rm;
  state_t            state;
  ctrl_t             ctl;

  assign opc     = ir_q[OPC_LO +: 4];
  assign rn      = ir_q[RN_LO +: RSEL_W];
  assign rm      = ir_q[RM_LO +: RSEL_W];
  assign fld_ext = {{(W-FLD_W){1'b0}}, ir_q[FLD_W-1:0]};

  fsmd_ctrl u_ctrl (
    .clk(clk), .rst(rst), .opcode(opc), .state(state), .ctl(ctl)
  );

  fsmd_regfile #(.W(W), .NREGS(NREGS)) u_rf (
    .clk(clk), .rst(rst), .we(ctl.rf_we), .wa(rn), .wd(rf_wd),
    .ra1(rn), .rd1(rf_rd1), .ra2(rm), .rd2(rf_rd2)
  );

  fsmd_alu #(.W(W)) u_alu (
    .a(rf_rd1), .b(rf_rd2), .op(ctl.alu_op), .y(alu_y), .zero(alu_z)
  );

  always_comb begin
    case (ctl.wsel)
      WSEL_MEM: rf_wd = mem_rdata;
      WSEL_IMM: rf_wd = fld_ext;
      default:  rf_wd = alu_y;
    endcase
  end

  always_comb begin
    case (ctl.asel)
      ASEL_DIR: mem_addr = fld_ext;
      ASEL_REG: mem_addr = rf_rd1;
      default:  mem_addr = pc_q;
    endcase
  end

  assign mem_wdata = ctl.wdata_rm ? rf_rd2 : rf_rd1;
  assign mem_re    = ctl.mem_re;
  assign mem_we    = ctl.mem_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
      ir_q <= '0;
    end else begin
      if (ctl.ir_ld) ir_q <= mem_rdata;
      if (ctl.pc_inc)              pc_q <= pc_q + W'(1);
      else if (ctl.pc_jz && alu_z) pc_q <= fld_ext;
    end
  end
endmodule

// File: rtl/fsmd_cpu_checker.sv
module fsmd_cpu_checker
  import fsmd_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] mem_addr,
  input logic         mem_re,
  input logic         mem_we,
  input logic [W-1:0] pc_q,
  input logic [W-1:0] ir_q,
  input logic [W-1:0] rf_rd1,
  input state_t       state
);
  p_rw_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(mem_re && mem_we));

  p_we_store_r10: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (state == S_STD || state == S_STI));

  p_first_fetch_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mem_addr == '0 && mem_re && !mem_we));

  p_pc_inc_r2: assert property (@(posedge clk) disable iff (rst)
    (state == S_FETCH) |=> (pc_q == $past(pc_q) + W'(1)));

  p_decode_next_r2: assert property (@(posedge clk) disable iff (rst)
    (state == S_FETCH) |=> (state == S_DECODE));

  p_exec_back_r2: assert property (@(posedge clk) disable iff (rst)
    (state != S_FETCH && state != S_DECODE) |=> (state == S_FETCH));

  p_nop_state_r9: assert property (@(posedge clk) disable iff (rst)
    (state == S_NOP) |-> (!mem_we && !mem_re && $stable(pc_q)));

  p_jz_taken_r8: assert property (@(posedge clk) disable iff (rst)
    (state == S_JZ && rf_rd1 == '0) |=> (pc_q == {{(W-8){1'b0}}, $past(ir_q[7:0])}));

  p_jz_held_r8: assert property (@(posedge clk) disable iff (rst)
    (state == S_JZ && rf_rd1 != '0) |=> $stable(pc_q));
endmodule

bind fsmd_cpu fsmd_cpu_checker #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_re(mem_re),
  .mem_we(mem_we), .pc_q(pc_q), .ir_q(ir_q), .rf_rd1(rf_rd1), .state(state)
);

// File: tb/fsmd_cpu_test.sv
module fsmd_cpu_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] HALT_PC = 16'h0014;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_re, mem_we;
  logic [15:0] mem [256];

  int checks = 0;
  int errors = 0;
  int cycle = 0;
  int writes_seen = 0;
  int fetch_n = 0;
  int fetch_cyc [4];
  logic [15:0] fetch_adr [4];
  logic [15:0] last_fetch = '0;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  fsmd_cpu uut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_re(mem_re), .mem_we(mem_we)
  );

  assign mem_rdata = mem[mem_addr[7:0]];

  always @(posedge clk) begin
    cycle <= cycle + 1;
    if (!rst && mem_we) mem[mem_addr[7:0]] <= mem_wdata;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic expect_write(input logic [15:0] a, input logic [15:0] d, input string req);
    exp_q.push_back({a, d});
    tag_q.push_back(req);
  endtask

  // monitor: compare each memory write with the scoreboard, log fetches
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_we) begin
        writes_seen++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R10 unexpected write", {mem_addr, mem_wdata}, 32'h0);
        end else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({mem_addr, mem_wdata} == e, t, {mem_addr, mem_wdata}, e);
        end
      end
      if (mem_re && mem_addr < 16'h0040) begin
        last_fetch = mem_addr;
        if (fetch_n < 4) begin
          fetch_cyc[fetch_n] = cycle;
          fetch_adr[fetch_n] = mem_addr;
        end
        fetch_n++;
      end
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    mem[0]  = 16'h3000; // R0 = 0
    mem[1]  = 16'h310A; // R1 = 10
    mem[2]  = 16'h3201; // R2 = 1
    mem[3]  = 16'h3300; // R3 = 0
    mem[4]  = 16'h6108; // if R1 == 0 goto 8
    mem[5]  = 16'h4010; // R0 += R1
    mem[6]  = 16'h5120; // R1 -= R2
    mem[7]  = 16'h6304; // goto 4
    mem[8]  = 16'h1080; // M[80] = R0
    mem[9]  = 16'h0480; // R4 = M[80]
    mem[10] = 16'h3590; // R5 = 0x90
    mem[11] = 16'h2540; // M[R5] = R4
    mem[12] = 16'h3600; // R6 = 0
    mem[13] = 16'h5620; // R6 -= R2
    mem[14] = 16'h1681; // M[81] = R6
    mem[15] = 16'h37F0; // R7 = 0xF0
    mem[16] = 16'h1783; // M[83] = R7
    mem[17] = 16'h7FFF; // no-op
    mem[18] = 16'hF123; // no-op
    mem[19] = 16'h1082; // M[82] = R0
    mem[20] = 16'h6314; // halt loop

    expect_write(16'h0080, 16'h0037, "R4 direct store of sum (R7 add, R8 loop)");
    expect_write(16'h0090, 16'h0037, "R5 indirect store of loaded word (R4 load)");
    expect_write(16'h0081, 16'hFFFF, "R7 subtract wraps");
    expect_write(16'h0083, 16'h00F0, "R6 immediate zero-extended");
    expect_write(16'h0082, 16'h0037, "R9 no-op left R0 intact");

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(mem_addr == 16'h0 && mem_re && !mem_we, "R1 fetch at 0 during reset",
          {mem_addr, 14'h0, mem_re, mem_we}, 32'h0000_0002);
    rst = 1'b0;
    #1;
    check(mem_addr == 16'h0, "R1 first address", mem_addr, 0);
    check(mem_re && !mem_we, "R1 enables", {mem_re, mem_we}, 2'b10);

    for (int k = 0; k < 2000 && exp_q.size() != 0; k++) @(negedge clk);
    check(exp_q.size() == 0, "R8 program reached its end (watchdog)", exp_q.size(), 0);
    repeat (30) @(negedge clk);

    check(fetch_cyc[1] - fetch_cyc[0] == 3, "R2 three cycles per instruction",
          fetch_cyc[1] - fetch_cyc[0], 3);
    check(fetch_cyc[3] - fetch_cyc[2] == 3, "R3 immediate decoded in three cycles",
          fetch_cyc[3] - fetch_cyc[2], 3);
    check({fetch_adr[0], fetch_adr[1]} == 32'h0000_0001, "R2 counter increments",
          {fetch_adr[0], fetch_adr[1]}, 32'h0000_0001);
    check({fetch_adr[2], fetch_adr[3]} == 32'h0002_0003, "R2 counter increments",
          {fetch_adr[2], fetch_adr[3]}, 32'h0002_0003);
    check(last_fetch == HALT_PC, "R8 taken jump holds at halt", last_fetch, HALT_PC);
    check(writes_seen == 5, "R10 write count", writes_seen, 5);
    check(mem[8'h80] == 16'h0037, "R4 memory 0x80", mem[8'h80], 16'h0037);
    check(mem[8'h90] == 16'h0037, "R5 memory 0x90", mem[8'h90], 16'h0037);
    check(mem[8'h81] == 16'hFFFF, "R7 memory 0x81", mem[8'h81], 16'hFFFF);
    check(mem[8'h83] == 16'h00F0, "R6 memory 0x83", mem[8'h83], 16'h00F0);
    check(mem[8'h82] == 16'h0037, "R9 memory 0x82", mem[8'h82], 16'h0037);
    check(mem[20] == 16'h6314, "R10 program words untouched", mem[20], 16'h6314);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule